// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block runs two kinds of transaction on a slow peripheral bus on behalf of an execution unit that runs on a faster core clock. The first kind is an interrupt-acknowledge cycle for one of four maskable interrupt lines. The acknowledged line is encoded on the address bus as a single cleared bit among set bits. The second kind is a simulated two-byte return-from-interrupt fetch. Older peripherals snoop the bus for this fetch to learn that a service routine has finished.

The peripheral clock is made inside the block. A programmable divisor sets its period in core-clock cycles. The block gives a one-cycle enable on the core clock that marks each peripheral rising edge, and it also drives the divided clock out on a pin. A transaction is accepted on the core clock. It then waits for the next peripheral rising edge and steps one bus cycle per peripheral clock. A wait input can stretch the transaction, and a one-cycle done pulse ends it. Only one transaction is in flight at a time.

Top module: `intack_busgen`

## Requirements
- R1: `pclk_o` has a period of D core cycles and rises on the core edge that ends a peripheral cycle. D is `div_i` limited to the range 2 to 8: values below 2 act as 2, and values above 8 act as 8.
- R2: While `intak_n_o` is low, `addr_o` bits 31 to 4 are all one. Bits 3 to 0 are one, except for a zero at the index of the acknowledged line (line 3 clears bit 3, and line 0 clears bit 0).
- R3: With `wait_n_i` held high, an acknowledge lasts five peripheral cycles. `intak_n_o` is low in cycles 2, 3 and 4, which is 3·D core cycles.
- R4: `wait_n_i` is sampled at the end of peripheral cycle 3. Each low sample repeats cycle 3, so `intak_n_o` stays low for (3+W)·D core cycles when W samples are low.
- R5: For lines 1 to 3, `fetch_n_o`, `iorq_n_o`, `iord_n_o` and `iowr_n_o` stay high for the whole acknowledge. For line 0, `fetch_n_o` and `iorq_n_o` go low together with `intak_n_o`, and `iord_n_o` and `iowr_n_o` stay high.
- R6: When several lines are pending in `irq_pend_i` (bit i is line i), the highest-numbered line is acknowledged. `ack_vec_o` holds that line one-hot until the next accepted acknowledge.
- R7: A return request (`req_ret_i`=1) gives two fetch cycles of three peripheral cycles each. `fetch_n_o`, `iorq_n_o` and `iord_n_o` are low in the second and third peripheral cycle of each fetch, so each strobe is low for 4·D core cycles in total. `data_o` carries 8'hED in the first fetch and 8'h4D in the second. `intak_n_o` stays high.
- R8: A transaction starts only on a peripheral rising edge. From the core edge that accepts the request to the core edge that raises `done_o`, the time is P·D + k core cycles, with 1 ≤ k ≤ D. P is the number of peripheral cycles the transaction lasts.
- R9: `busy_o` rises on the edge that accepts a request and stays high through the single-cycle `done_o` pulse. Requests made while busy are dropped.
- R10: An acknowledge request with `irq_pend_i` equal to zero is not accepted.
- R11: After reset, `busy_o` and `done_o` are low, every strobe is high, `addr_o` is zero, `data_oe_o` is low and `ack_vec_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_i | input | 4 | Peripheral clock divisor |
| req_i | input | 1 | Request strobe, one core cycle |
| req_ret_i | input | 1 | 1: return fetch, 0: interrupt acknowledge |
| irq_pend_i | input | 4 | Pending maskable lines, bit i = line i |
| wait_n_i | input | 1 | Wait request from the bus, active low |
| busy_o | output | 1 | Transaction accepted and not yet finished |
| done_o | output | 1 | One-cycle completion pulse |
| ack_vec_o | output | 4 | One-hot line of the last acknowledge |
| pclk_o | output | 1 | Divided peripheral clock |
| addr_o | output | 32 | Peripheral address bus |
| data_o | output | 8 | Opcode byte during the return fetch |
| data_oe_o | output | 1 | Data bus drive enable |
| intak_n_o | output | 1 | Interrupt acknowledge strobe |
| fetch_n_o | output | 1 | Instruction fetch strobe |
| iorq_n_o | output | 1 | Peripheral request strobe |
| iord_n_o | output | 1 | Peripheral read strobe |
| iowr_n_o | output | 1 | Peripheral write strobe |

## Verification
The bench builds the block with its default parameters: four interrupt lines, a 32-bit address and a divisor range of 2 to 8. This puts every line position and both ends of the divisor range within reach. The bench drives the divisor input to 2, 3, 4, 5, 7 and 8, and also to 1 and 12 so that the limiting to the legal range is exercised. At each divisor it checks strobe widths and start latency. Held-low waits of one to three samples show that cycle 3 repeats by whole peripheral cycles.

// File: rtl/intack_pkg.sv
package intack_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_ARMED,
      SQ_RUN,
      SQ_FIN
   } sq_state_e;

   // opcode bytes of the return-from-interrupt fetch, in bus order
   localparam logic [7:0] RET_OP_FIRST  = 8'hED;
   localparam logic [7:0] RET_OP_SECOND = 8'h4D;

   // phase numbering, zero based, one phase per peripheral clock
   localparam logic [2:0] ACK_LAST_PH  = 3'd4;
   localparam logic [2:0] ACK_WAIT_PH  = 3'd2;
   localparam logic [2:0] RET_LAST_PH  = 3'd5;
   localparam logic [2:0] RET_HALF_PH  = 3'd3;

endpackage

// File: rtl/pbus_clkdiv.sv
module pbus_clkdiv #(
   parameter  int DIV_MIN = 2,
   parameter  int DIV_MAX = 8,
   localparam int CW      = $clog2(DIV_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] div_i,
   output logic          tick_o,
   output logic          pclk_o
);

   localparam logic [CW-1:0] LO_V = CW'(DIV_MIN);
   localparam logic [CW-1:0] HI_V = CW'(DIV_MAX);

   if (DIV_MIN < 2 || DIV_MAX < DIV_MIN) begin : g_bad_range
      $error("pbus_clkdiv: divisor range must satisfy 2 <= DIV_MIN <= DIV_MAX");
   end

   logic [CW-1:0] div_eff;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_inc;
   logic [CW-1:0] high_len;
   logic          pclk_q;

   always_comb begin
      if (div_i < LO_V)      div_eff = LO_V;
      else if (div_i > HI_V) div_eff = HI_V;
      else                   div_eff = div_i;
      high_len = (div_eff + 1'b1) >> 1;
      cnt_inc  = cnt + 1'b1;
   end

   // the last core cycle of a peripheral period; a shrunken divisor wraps at once
   assign tick_o = (cnt >= div_eff - 1'b1);
   assign pclk_o = pclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         pclk_q <= 1'b0;
      end else if (tick_o) begin
         cnt    <= '0;
         pclk_q <= 1'b1;
      end else begin
         cnt    <= cnt_inc;
         pclk_q <= (cnt_inc < high_len);
      end
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o) else $error("tick on consecutive cycles"); // R1
   AST_PCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> pclk_o) else $error("pclk not high after tick"); // R1

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);

   if (N < 2) begin : g_bad_n
      $error("irq_prio: at least two lines required");
   end

   for (genvar i = 0; i < N; i++) begin : g_line
      if (i == N - 1) begin : g_top
         assign grant_o[i] = req_i[i];
      end else begin : g_lower
         assign grant_o[i] = req_i[i] & ~(|req_i[N-1:i+1]);
      end
   end

   always_comb begin
      AST_GRANT_ONEHOT: assert (!(|req_i) || $onehot(grant_o))
         else $error("grant not one-hot"); // R6
   end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import intack_pkg::*;
#(
   parameter int N  = 4,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic          req_i,
   input  logic          req_ret_i,
   input  logic [N-1:0]  grant_i,
   input  logic          wait_n_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [N-1:0]  line_o,
   output logic [AW-1:0] addr_o,
   output logic [7:0]    data_o,
   output logic          data_oe_o,
   output logic          intak_n_o,
   output logic          fetch_n_o,
   output logic          iorq_n_o,
   output logic          iord_n_o,
   output logic          iowr_n_o
);

   if (AW <= N) begin : g_bad_aw
      $error("pbus_seq: address must be wider than the line field");
   end

   sq_state_e    st;
   logic [2:0]   ph;
   logic         is_ret;
   logic [N-1:0] line_q;

   logic         accept, run, last_ph, wait_ph, second, ack_on, ret_on;
   logic [2:0]   sub;

   always_comb begin
      accept  = (st == SQ_IDLE) && req_i && (req_ret_i || (|grant_i));
      run     = (st == SQ_RUN);
      second  = (ph >= RET_HALF_PH);
      sub     = second ? (ph - RET_HALF_PH) : ph;
      last_ph = is_ret ? (ph == RET_LAST_PH) : (ph == ACK_LAST_PH);
      wait_ph = is_ret ? (sub == 3'd1) : (ph == ACK_WAIT_PH);
      ack_on  = run && !is_ret && (ph >= 3'd1) && (ph <= 3'd3);
      ret_on  = run && is_ret && (sub != 3'd0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         ph     <= '0;
         is_ret <= 1'b0;
         line_q <= '0;
      end else begin
         unique case (st)
            SQ_IDLE: if (accept) begin
               st     <= SQ_ARMED;
               is_ret <= req_ret_i;
               if (!req_ret_i) line_q <= grant_i;
            end
            SQ_ARMED: if (tick_i) begin
               st <= SQ_RUN;
               ph <= '0;
            end
            SQ_RUN: if (tick_i) begin
               if (wait_ph && !wait_n_i) begin
                  ph <= ph;
               end else if (last_ph) begin
                  st <= SQ_FIN;
                  ph <= '0;
               end else begin
                  ph <= ph + 3'd1;
               end
            end
            SQ_FIN: st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o    = (st != SQ_IDLE);
   assign done_o    = (st == SQ_FIN);
   assign line_o    = line_q;
   assign addr_o    = (run && !is_ret) ? ~AW'(line_q) : '0;
   assign data_oe_o = run && is_ret;
   assign data_o    = second ? RET_OP_SECOND : RET_OP_FIRST;
   assign intak_n_o = !ack_on;
   assign fetch_n_o = !((ack_on && line_q[0]) || ret_on);
   assign iorq_n_o  = !((ack_on && line_q[0]) || ret_on);
   assign iord_n_o  = !ret_on;
   assign iowr_n_o  = 1'b1;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o) else $error("done longer than one cycle"); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o) else $error("busy dropped early"); // R9
   AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> $past(tick_i)) else $error("start off a peripheral edge"); // R8
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_on && ph == ACK_WAIT_PH && tick_i && !wait_n_i) |=> !intak_n_o)
      else $error("wait did not stretch acknowledge"); // R4
   AST_RET_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> intak_n_o) else $error("acknowledge during return fetch"); // R7

endmodule

// File: rtl/intack_busgen.sv
module intack_busgen #(
   parameter  int NLINE   = 4,
   parameter  int AW      = 32,
   parameter  int DIV_MIN = 2,
   parameter  int DIV_MAX = 8,
   localparam int DIV_W   = $clog2(DIV_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             req_i,
   input  logic             req_ret_i,
   input  logic [NLINE-1:0] irq_pend_i,
   input  logic             wait_n_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [NLINE-1:0] ack_vec_o,
   output logic             pclk_o,
   output logic [AW-1:0]    addr_o,
   output logic [7:0]       data_o,
   output logic             data_oe_o,
   output logic             intak_n_o,
   output logic             fetch_n_o,
   output logic             iorq_n_o,
   output logic             iord_n_o,
   output logic             iowr_n_o
);

   logic             tick;
   logic [NLINE-1:0] grant;

   pbus_clkdiv #(.DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_i  (div_i),
      .tick_o (tick),
      .pclk_o (pclk_o)
   );

   irq_prio #(.N(NLINE)) u_prio (
      .req_i   (irq_pend_i),
      .grant_o (grant)
   );

   pbus_seq #(.N(NLINE), .AW(AW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .req_i     (req_i),
      .req_ret_i (req_ret_i),
      .grant_i   (grant),
      .wait_n_i  (wait_n_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .line_o    (ack_vec_o),
      .addr_o    (addr_o),
      .data_o    (data_o),
      .data_oe_o (data_oe_o),
      .intak_n_o (intak_n_o),
      .fetch_n_o (fetch_n_o),
      .iorq_n_o  (iorq_n_o),
      .iord_n_o  (iord_n_o),
      .iowr_n_o  (iowr_n_o)
   );

   AST_ACK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      !intak_n_o |-> ((&addr_o[AW-1:NLINE]) && ($countones(addr_o[NLINE-1:0]) == NLINE - 1)))
      else $error("acknowledge address not single-zero"); // R2
   AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      (!intak_n_o && !ack_vec_o[0]) |-> (fetch_n_o && iorq_n_o && iord_n_o && iowr_n_o))
      else $error("extra strobe during upper-line acknowledge"); // R5

endmodule

// File: tb/sim_intack_busgen.sv
module sim_intack_busgen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  div_i = 4'd2;
   logic        req_i = 1'b0;
   logic        req_ret_i = 1'b0;
   logic [3:0]  irq_pend_i = 4'd0;
   logic        wait_n_i = 1'b1;
   logic        busy_o, done_o, pclk_o, data_oe_o;
   logic [3:0]  ack_vec_o;
   logic [31:0] addr_o;
   logic [7:0]  data_o;
   logic        intak_n_o, fetch_n_o, iorq_n_o, iord_n_o, iowr_n_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   intack_busgen u0 (
      .clk(clk), .rst_n(rst_n), .div_i(div_i), .req_i(req_i), .req_ret_i(req_ret_i),
      .irq_pend_i(irq_pend_i), .wait_n_i(wait_n_i), .busy_o(busy_o), .done_o(done_o),
      .ack_vec_o(ack_vec_o), .pclk_o(pclk_o), .addr_o(addr_o), .data_o(data_o),
      .data_oe_o(data_oe_o), .intak_n_o(intak_n_o), .fetch_n_o(fetch_n_o),
      .iorq_n_o(iorq_n_o), .iord_n_o(iord_n_o), .iowr_n_o(iowr_n_o)
   );

   // vector: {ret, pend[3:0], div[3:0], waits[1:0], expected grant[3:0]}
   localparam int NV = 10;
   localparam logic [14:0] VEC [NV] = '{
      {1'b0, 4'b1000, 4'd2,  2'd0, 4'b1000},
      {1'b0, 4'b0110, 4'd3,  2'd1, 4'b0100},
      {1'b0, 4'b0011, 4'd5,  2'd0, 4'b0010},
      {1'b0, 4'b0001, 4'd8,  2'd2, 4'b0001},
      {1'b1, 4'b0000, 4'd4,  2'd0, 4'b0000},
      {1'b0, 4'b1111, 4'd2,  2'd3, 4'b1000},
      {1'b1, 4'b0101, 4'd7,  2'd0, 4'b0000},
      {1'b0, 4'b0100, 4'd1,  2'd0, 4'b0100},
      {1'b0, 4'b0010, 4'd12, 2'd1, 4'b0010},
      {1'b0, 4'b0001, 4'd3,  2'd0, 4'b0001}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int clampd(input int d);
      if (d < 2) return 2;
      if (d > 8) return 8;
      return d;
   endfunction

   task automatic wait_rise();
      logic prv;
      prv = pclk_o;
      @(negedge clk);
      while (!(prv === 1'b0 && pclk_o === 1'b1)) begin
         prv = pclk_o;
         @(negedge clk);
      end
   endtask

   task automatic meas_period(output int p);
      logic prv;
      wait_rise();
      p   = 0;
      prv = pclk_o;
      forever begin
         @(negedge clk);
         p++;
         if (prv === 1'b0 && pclk_o === 1'b1) break;
         prv = pclk_o;
      end
   endtask

   task automatic run_vec(input logic [14:0] v);
      logic       ret;
      logic [3:0] pend, egr;
      int d, w, p, c, per, wc;
      int n_intak, n_fetch, n_iorq, n_iord, npulse;
      logic seen_intak, addr_bad, prev_fetch, wr_bad;
      logic [7:0] b0, b1;
      ret  = v[14];
      pend = v[13:10];
      d    = clampd(int'(v[9:6]));
      w    = int'(v[5:4]);
      egr  = v[3:0];
      div_i = v[9:6];
      repeat (20) @(negedge clk);
      meas_period(per);
      chk("R1 pclk period", per, d);

      @(negedge clk);
      req_i = 1'b1; req_ret_i = ret; irq_pend_i = pend;
      @(negedge clk);
      req_i = 1'b0;
      chk("R9 busy after accept", busy_o, 1);
      c = 0; n_intak = 0; n_fetch = 0; n_iorq = 0; n_iord = 0; npulse = 0; wc = 0;
      seen_intak = 1'b0; addr_bad = 1'b0; prev_fetch = 1'b1; wr_bad = 1'b0;
      b0 = '0; b1 = '0;
      forever begin
         if (done_o === 1'b1) break;
         if (!intak_n_o) begin
            n_intak++;
            if (addr_o !== ~{28'd0, egr}) addr_bad = 1'b1;
         end
         if (!fetch_n_o) n_fetch++;
         if (!iorq_n_o)  n_iorq++;
         if (!iord_n_o)  n_iord++;
         if (!iowr_n_o)  wr_bad = 1'b1;
         if (!fetch_n_o && prev_fetch) begin
            if (npulse == 0) b0 = data_o;
            if (npulse == 1) b1 = data_o;
            npulse++;
         end
         prev_fetch = fetch_n_o;
         if (!intak_n_o && !seen_intak) begin
            seen_intak = 1'b1;
            if (w > 0) begin
               wait_n_i = 1'b0;
               wc = (1 + w) * d;
            end
         end else if (wc > 0) begin
            wc--;
            if (wc == 0) wait_n_i = 1'b1;
         end
         @(negedge clk);
         c++;
      end
      wait_n_i = 1'b1;
      p = ret ? 6 : 5 + w;
      chk("R8 latency lower bound", (c >= p * d + 1), 1);
      chk("R8 latency upper bound", (c <= p * d + d), 1);
      chk("R5 write strobe idle", wr_bad, 0);
      if (ret) begin
         chk("R7 fetch pulses", npulse, 2);
         chk("R7 first opcode", b0, 8'hED);
         chk("R7 second opcode", b1, 8'h4D);
         chk("R7 fetch width", n_fetch, 4 * d);
         chk("R7 request width", n_iorq, 4 * d);
         chk("R7 read width", n_iord, 4 * d);
         chk("R7 no acknowledge", n_intak, 0);
      end else begin
         chk("R6 ack vector", ack_vec_o, egr);
         chk("R2 acknowledge address", addr_bad, 0);
         if (w == 0) chk("R3 acknowledge width", n_intak, 3 * d);
         else        chk("R4 stretched acknowledge width", n_intak, (3 + w) * d);
         chk("R5 read strobe idle", n_iord, 0);
         if (egr[0]) begin
            chk("R5 line0 fetch", n_fetch, n_intak);
            chk("R5 line0 request", n_iorq, n_intak);
         end else begin
            chk("R5 fetch idle", n_fetch, 0);
            chk("R5 request idle", n_iorq, 0);
         end
      end
      @(negedge clk);
      chk("R9 done single cycle", done_o, 0);
      chk("R9 busy clear", busy_o, 0);
   endtask

   initial begin
      #(200000 * 20);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11 busy", busy_o, 0);
      chk("R11 done", done_o, 0);
      chk("R11 strobes", {intak_n_o, fetch_n_o, iorq_n_o, iord_n_o, iowr_n_o}, 5'b11111);
      chk("R11 address", addr_o, 0);
      chk("R11 data enable", data_oe_o, 0);
      chk("R11 ack vector", ack_vec_o, 0);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // R9: a request made while busy is dropped
      begin
         int ndone;
         logic leak;
         div_i = 4'd2;
         repeat (6) @(negedge clk);
         req_i = 1'b1; req_ret_i = 1'b0; irq_pend_i = 4'b0100;
         @(negedge clk);
         req_i = 1'b0;
         repeat (3) @(negedge clk);
         req_i = 1'b1; req_ret_i = 1'b1;
         @(negedge clk);
         req_i = 1'b0; req_ret_i = 1'b0;
         ndone = 0;
         while (busy_o) begin
            if (done_o) ndone++;
            @(negedge clk);
         end
         chk("R9 one completion", ndone, 1);
         chk("R9 ack vector kept", ack_vec_o, 4'b0100);
         leak = 1'b0;
         repeat (30) begin
            if (busy_o || !fetch_n_o || data_oe_o) leak = 1'b1;
            @(negedge clk);
         end
         chk("R9 dropped request left no fetch", leak, 0);
      end

      // R10: acknowledge request with nothing pending
      begin
         logic moved;
         irq_pend_i = 4'b0000;
         req_i = 1'b1; req_ret_i = 1'b0;
         @(negedge clk);
         req_i = 1'b0;
         chk("R10 not accepted", busy_o, 0);
         moved = 1'b0;
         repeat (30) begin
            if (busy_o || !intak_n_o || done_o) moved = 1'b1;
            @(negedge clk);
         end
         chk("R10 bus quiet", moved, 0);
         chk("R10 ack vector unchanged", ack_vec_o, 4'b0100);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule